// File: doc/BRIEF.md
# SDRAM Row Boundary Decoder

This block takes a physical address and works out which of four SDRAM chip-select rows it falls in. Software sets each row with one 8-bit cumulative upper limit. The limit in bytes is that value shifted left by 24, so every limit lands on a 16 MB boundary. A row starts where the row below it ends, and row 0 starts at address zero. A row whose limit equals the limit below it holds no memory. The decoder marks such a row empty and never selects it.

Each lookup is offered with a valid strobe. The block compares the address against all limits at once. One clock later it returns a one-hot row select, the binary row index and a miss flag. The miss flag covers addresses at or above the top limit. Two further flags are available at all times: one bit per row showing which rows are empty, and a configuration-error flag. That flag is raised when the limits are not in non-decreasing order.

Top module: `sdram_row_map`

## Requirements
- R1: While reset is asserted and after it is released, all four limits are zero. `rowEmpty` reads 4'b1111, `cfgError` is 0, and `outValid`, `rowHit`, `rowIdx` and `rowMiss` are all zero.
- R2: A write cycle with `cfgWrEn` high loads `cfgData` into the limit register numbered by `cfgAddr`, where 0 is the lowest row. Lookups and flags use the new value from the next clock edge onward.
- R3: A lookup selects row i when limit(i-1) <= `reqAddr[31:24]` < limit(i), with limit(-1) taken as 0. The result is `rowHit` with only bit i set and `rowIdx` = i. Address bits 23:0 do not affect the result, so `(limit<<24)-1` is still inside the row and `limit<<24` is outside it.
- R4: A row whose limit equals the limit below it is empty. For row 0 that means a limit of 0. An empty row shows its bit set in `rowEmpty` and is never selected.
- R5: A lookup that matches no row raises `rowMiss`, with `rowHit` = 0 and `rowIdx` = 0. When the limits are in order, this happens exactly when `reqAddr[31:24]` >= limit(3).
- R6: The result of a lookup appears one clock after the edge where `reqValid` is sampled high, and `outValid` is 1 for that cycle. If `reqValid` was low, the next cycle shows `outValid`, `rowHit`, `rowIdx` and `rowMiss` all 0.
- R7: `cfgError` is 1 exactly when some limit(i) is less than limit(i-1), for i from 1 to 3.
- R8: When more than one row matches, as can happen with out-of-order limits, the lowest-numbered matching row is selected.
- R9: A lookup sampled on the same edge as a limit write is decoded against the limits as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Limit register write strobe |
| cfgAddr | input | 2 | Row number of the limit to write |
| cfgData | input | 8 | New limit value, in 16 MB units |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Physical address to decode |
| outValid | output | 1 | Registered result is valid |
| rowHit | output | 4 | One-hot selected row |
| rowIdx | output | 2 | Binary index of the selected row |
| rowMiss | output | 1 | Address lies in no row |
| rowEmpty | output | 4 | Per-row unpopulated flag |
| cfgError | output | 1 | Limits are not non-decreasing |

## Verification
The first lookups run with every limit still at zero, which shows that an empty map always misses. Next comes an ordered map with a hole in row 2. Addresses one byte below and exactly at each boundary show whether the decoder looks only at the top byte, and whether it skips the empty row. A limit write made in the same cycle as a lookup shows whether the lookup used the old limits or the new ones. Last, an out-of-order map checks the error flag and confirms that the lowest-numbered matching row wins when two rows match.

// File: rtl/rowmap_pkg.sv
package rowmap_pkg;
  parameter int ROWS    = 4;
  parameter int LIMIT_W = 8;
  parameter int ADDR_W  = 32;
  parameter int IDX_W   = $clog2(ROWS);

  // Strobes passed from control to datapath
  typedef struct packed {
    logic             capture;  // register a lookup result
    logic             load;     // write a limit register
    logic [IDX_W-1:0] loadSel;  // which limit to write
  } rowCtrl_t;
endpackage

// File: rtl/rowmap_ctrl.sv
module rowmap_ctrl
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS = ROWS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgAddr,
  input  logic             reqValid,
  output rowCtrl_t         ctrl,
  output logic             outValid
);
  logic addrInRange;

  generate
    if ((1 << IDX_W) == NUM_ROWS) begin : g_pow2
      assign addrInRange = 1'b1;
    end else begin : g_npow2
      assign addrInRange = (int'(cfgAddr) < NUM_ROWS);
    end
  endgenerate

  always_comb begin
    ctrl.capture = reqValid;
    ctrl.load    = cfgWrEn && addrInRange;
    ctrl.loadSel = cfgAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  // R6: a valid result only ever follows a sampled request
  p_valid_follows_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(reqValid));
endmodule

// File: rtl/rowmap_datapath.sv
module rowmap_datapath
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS = ROWS,
  parameter int LIM_W    = LIMIT_W,
  parameter int A_W      = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  rowCtrl_t            ctrl,
  input  logic [LIM_W-1:0]    cfgData,
  input  logic [A_W-1:0]      reqAddr,
  input  logic                outValid,
  output logic [NUM_ROWS-1:0] rowHit,
  output logic [IDX_W-1:0]    rowIdx,
  output logic                rowMiss,
  output logic [NUM_ROWS-1:0] rowEmpty,
  output logic                cfgError
);
  localparam int HI_LSB = A_W - LIM_W;

  logic [LIM_W-1:0]    limitQ  [NUM_ROWS];
  logic [LIM_W-1:0]    baseVal [NUM_ROWS];
  logic [NUM_ROWS-1:0] matchVec;
  logic [NUM_ROWS-1:0] dropVec;
  logic [NUM_ROWS-1:0] pickHot;
  logic [IDX_W-1:0]    pickIdx;
  logic [LIM_W-1:0]    addrHi;

  assign addrHi = reqAddr[A_W-1:HI_LSB];

  generate
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) limitQ[i] <= '0;
        else if (ctrl.load && int'(ctrl.loadSel) == i) limitQ[i] <= cfgData;
      end

      if (i == 0) begin : g_first
        assign baseVal[i] = '0;
        assign dropVec[i] = 1'b0;
      end else begin : g_next
        assign baseVal[i] = limitQ[i-1];
        assign dropVec[i] = (limitQ[i] < limitQ[i-1]);
      end

      assign rowEmpty[i] = (limitQ[i] == baseVal[i]);
      assign matchVec[i] = (addrHi >= baseVal[i]) && (addrHi < limitQ[i]);
    end
  endgenerate

  assign cfgError = |dropVec;

  // lowest-numbered match wins
  always_comb begin
    pickHot = '0;
    pickIdx = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        pickHot = '0;
        pickHot[i] = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowHit  <= '0;
      rowIdx  <= '0;
      rowMiss <= 1'b0;
    end else if (ctrl.capture) begin
      rowHit  <= pickHot;
      rowIdx  <= pickIdx;
      rowMiss <= ~|matchVec;
    end else begin
      rowHit  <= '0;
      rowIdx  <= '0;
      rowMiss <= 1'b0;
    end
  end

  // R3: never more than one row selected
  p_onehot_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowHit));
  // R3: index names the selected row
  p_idx_agrees_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !rowMiss) |-> rowHit[rowIdx]);
  // R5: a valid result is either exactly one hit or a miss
  p_hit_xor_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (rowMiss == (rowHit == '0)));
  // R4: an empty row is never chosen
  p_no_empty_pick_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((rowHit & $past(rowEmpty)) == '0));
  // R6: idle cycles show nothing
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (rowHit == '0 && !rowMiss && rowIdx == '0));
endmodule

// File: rtl/sdram_row_map.sv
module sdram_row_map
  import rowmap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [LIMIT_W-1:0] cfgData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               outValid,
  output logic [ROWS-1:0]    rowHit,
  output logic [IDX_W-1:0]   rowIdx,
  output logic               rowMiss,
  output logic [ROWS-1:0]    rowEmpty,
  output logic               cfgError
);
  rowCtrl_t ctrl;

  rowmap_ctrl #(.NUM_ROWS(ROWS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .reqValid (reqValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  rowmap_datapath #(.NUM_ROWS(ROWS), .LIM_W(LIMIT_W), .A_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cfgData  (cfgData),
    .reqAddr  (reqAddr),
    .outValid (outValid),
    .rowHit   (rowHit),
    .rowIdx   (rowIdx),
    .rowMiss  (rowMiss),
    .rowEmpty (rowEmpty),
    .cfgError (cfgError)
  );
endmodule

// File: tb/sdram_row_map_test.sv
module sdram_row_map_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        outValid, rowMiss, cfgError;
  logic [3:0]  rowHit, rowEmpty;
  logic [1:0]  rowIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  int mLim[4];
  bit eValid, eMiss;
  int eIdx;
  logic [3:0] eHit;

  always #5 clk = ~clk;

  sdram_row_map uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr),
    .outValid(outValid), .rowHit(rowHit), .rowIdx(rowIdx),
    .rowMiss(rowMiss), .rowEmpty(rowEmpty), .cfgError(cfgError)
  );

  function automatic int lookupRow(int hi);
    int prev = 0;
    for (int r = 0; r < 4; r++) begin
      if (hi >= prev && hi < mLim[r]) return r;
      prev = mLim[r];
    end
    return -1;
  endfunction

  function automatic logic [3:0] expEmpty();
    logic [3:0] v;
    int prev = 0;
    for (int r = 0; r < 4; r++) begin
      v[r] = (mLim[r] == prev);
      prev = mLim[r];
    end
    return v;
  endfunction

  function automatic bit expErr();
    for (int r = 1; r < 4; r++) if (mLim[r] < mLim[r-1]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 4; r++) mLim[r] = 0;
      eValid = 0; eMiss = 0; eIdx = 0; eHit = '0;
    end else begin
      int row;
      eValid = reqValid;
      eHit = '0; eIdx = 0; eMiss = 0;
      if (reqValid) begin
        row = lookupRow(int'(reqAddr[31:24]));
        if (row < 0) eMiss = 1;
        else begin eHit[row] = 1'b1; eIdx = row; end
      end
      if (cfgWrEn) mLim[cfgAddr] = int'(cfgData);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({tag, "/R6"}, "outValid", int'(outValid), int'(eValid));
      check({tag, "/R3"}, "rowHit", int'(rowHit), int'(eHit));
      check({tag, "/R3"}, "rowIdx", int'(rowIdx), eIdx);
      check({tag, "/R5"}, "rowMiss", int'(rowMiss), int'(eMiss));
      check({tag, "/R4"}, "rowEmpty", int'(rowEmpty), int'(expEmpty()));
      check({tag, "/R7"}, "cfgError", int'(cfgError), int'(expErr()));
    end
  end

  task automatic step(bit wr, int sel, int val, bit rv, logic [31:0] a);
    @(negedge clk);
    cfgWrEn = wr; cfgAddr = 2'(sel); cfgData = 8'(val);
    reqValid = rv; reqAddr = a;
    @(negedge clk);
    cfgWrEn = 0; reqValid = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values seen while reset is held
    check("R1", "rowEmpty in reset", int'(rowEmpty), 15);
    check("R1", "cfgError in reset", int'(cfgError), 0);
    check("R1", "outputs in reset", int'({outValid, rowHit, rowIdx, rowMiss}), 0);
    rstN = 1;
    // R5: empty map misses everything
    tag = "R5";
    step(0, 0, 0, 1, 32'h0000_0000);
    step(0, 0, 0, 1, 32'hFFFF_FFFF);
    // R2: program ordered map with hole in row 2
    tag = "R2";
    step(1, 0, 8'h04, 0, 0);
    step(1, 1, 8'h08, 0, 0);
    step(1, 2, 8'h08, 0, 0);
    step(1, 3, 8'h20, 0, 0);
    // R3/R4/R5: boundaries
    tag = "R3";
    step(0, 0, 0, 1, 32'h0000_0000);
    step(0, 0, 0, 1, 32'h03FF_FFFF);
    step(0, 0, 0, 1, 32'h0400_0000);
    step(0, 0, 0, 1, 32'h07FF_FFFF);
    tag = "R4";
    step(0, 0, 0, 1, 32'h0800_0000);
    step(0, 0, 0, 1, 32'h1FFF_FFFF);
    tag = "R5";
    step(0, 0, 0, 1, 32'h2000_0000);
    step(0, 0, 0, 1, 32'hFFFF_FFFF);
    // R6: back-to-back requests then idle gap
    tag = "R6";
    @(negedge clk); reqValid = 1; reqAddr = 32'h0500_0000;
    @(negedge clk); reqAddr = 32'h0100_0000;
    @(negedge clk); reqValid = 0;
    repeat (2) @(negedge clk);
    // R9: lookup alongside a write of the same limit
    tag = "R9";
    step(1, 3, 8'h40, 1, 32'h3000_0000);
    step(0, 0, 0, 1, 32'h3000_0000);
    // R7/R8: out-of-order limits
    tag = "R7";
    step(1, 0, 8'h10, 0, 0);
    step(1, 1, 8'h05, 0, 0);
    step(1, 2, 8'h20, 0, 0);
    step(1, 3, 8'h30, 0, 0);
    tag = "R8";
    step(0, 0, 0, 1, 32'h0700_0000);
    step(0, 0, 0, 1, 32'h1200_0000);
    step(0, 0, 0, 1, 32'h3000_0000);
    // R7: repair order, flag clears
    tag = "R7";
    step(1, 1, 8'h18, 1, 32'h1200_0000);
    step(0, 0, 0, 1, 32'h1200_0000);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule